// File: doc/BRIEF.md
# Level-Masked Priority Interrupt Controller

This block collects service requests from a set of peripheral sources and decides which one, if any, the processor should take next. Each source keeps a sticky cause bit, an enable bit and a 3-bit urgency level. A source asks for service only when its cause and enable bits are both set and its level is not the reserved value 7. Among the sources that are asking, a combinational arbiter picks the most urgent level and forwards it.

The processor side keeps a current-level mask and a global enable flag. A forwarded level is taken only when it is strictly more urgent than the mask, the global flag is set, the block is not busy and the context stack has room. Acceptance happens only on a cycle where the instruction-boundary strobe is high. On acceptance the old mask and enable flag are pushed, the mask takes the new level, and a one-cycle entry pulse reports the winning source. A return strobe pops the saved context back. Both entry and return keep the block busy for a fixed number of cycles derived from the machine-cycle parameter `WAIT_N`. Software clears a cause bit through the write port, and that ends the request.

The control FSM has three states. `ST_IDLE` is the handler or background state, in which acceptance or return may start. `ST_ENTER` counts the entry cost. `ST_LEAVE` counts the return cost. Its transitions are:

- `IDLE->LEAVE` on a return with a non-empty stack.
- `IDLE->ENTER` on an acceptance.
- `ENTER->IDLE` and `LEAVE->IDLE` when the counter reaches zero.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A source requests only when its cause bit is 1, its enable bit is 1 and its level is not 7. A high `cause_set[i]` sets cause bit i, which then holds. If a set pulse and a clear write to the same source land in the same cycle, the set wins.
- R2: A write (`wr_en`=1) to source `wr_idx` acts by `wr_kind`. Kind 0 loads the enable bit from `wr_data[0]`. Kind 1 loads the level from `wr_data[2:0]`. Kind 2 clears the cause bit. Kind 3 changes nothing.
- R3: `req_lvl` shows the numerically smallest level among requesting sources, or 7 when none requests. Among sources of equal level, the lowest index wins.
- R4: A request is accepted only if `req_lvl` < `cur_mask` (strictly) and `ie_flag`=1, with the block idle. An equal or larger level is never taken.
- R5: On acceptance, `cur_mask` becomes the accepted level, the previous mask and `ie_flag` are pushed onto the stack, and `ie_flag` is left unchanged.
- R6: Acceptance happens only at a clock edge where `insn_end` is 1.
- R7: `take_pulse` is high for exactly the one cycle after the accepting edge. `take_idx` gives the accepted source index and holds it until the next acceptance.
- R8: After acceptance, `busy` is 1 for exactly 24+6·`WAIT_N` cycles, and no acceptance occurs while busy.
- R9: When the block is idle with a non-empty stack, `ret_req`=1 pops the saved mask and enable flag and keeps `busy` high for 15+6·`WAIT_N` cycles. The pop takes precedence over an acceptance in the same cycle. A return while busy or with an empty stack is ignored.
- R10: `ie_wr`=1 loads `ie_flag` from `ie_val`, except in a cycle where a return pops, in which case the popped value wins.
- R11: After reset, all causes and enables are 0, all levels are 7, `cur_mask`=7, `ie_flag`=0, `busy`=0, `take_pulse`=0 and `take_idx`=0.
- R12: The stack holds `STK_DEPTH` contexts. While it is full, no request is accepted, even one more urgent than the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cause_set | input | NUM_SRC | Per-source event pulse that sets the cause bit |
| wr_en | input | 1 | Source register write strobe |
| wr_idx | input | SRC_W | Source addressed by the write |
| wr_kind | input | 2 | Write action: 0 enable, 1 level, 2 clear cause, 3 none |
| wr_data | input | 3 | Write data (bit 0 for enable, all bits for level) |
| ie_wr | input | 1 | Global enable write strobe |
| ie_val | input | 1 | Value for the global enable flag |
| insn_end | input | 1 | Instruction-boundary strobe |
| ret_req | input | 1 | Return-from-handler strobe |
| req_lvl | output | 3 | Level of the winning request, 7 when none |
| cur_mask | output | 3 | Current level mask |
| ie_flag | output | 1 | Global interrupt enable flag |
| busy | output | 1 | Entry or return sequence in progress |
| take_pulse | output | 1 | One-cycle acceptance pulse |
| take_idx | output | SRC_W | Index of the last accepted source |

## Verification
A corrupted source bit or a wrong arbiter choice shows on `req_lvl` in the cycle after the write or event that caused it. A wrong mask, enable flag or stack entry stays hidden until the next acceptance decision or return. At that point it appears as a missing or extra `take_pulse`, or as a wrong `cur_mask` right after a pop. A counter that is off by one moves the falling edge of `busy`, so the length of every entry and return is measured. The reference model is compared with every output on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/lic_pkg.sv
package lic_pkg;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_OFF = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTER = 2'd1,
        ST_LEAVE = 2'd2
    } lic_state_e;

    typedef enum logic [1:0] {
        WK_ENABLE = 2'd0,
        WK_LEVEL  = 2'd1,
        WK_CLEAR  = 2'd2,
        WK_NONE   = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic [LVL_W-1:0] mask;
        logic             ie;
    } ctx_t;

endpackage

// File: rtl/lic_src_bank.sv
module lic_src_bank
    import lic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            cause_set,
    input  logic                          wr_en,
    input  logic [SRC_W-1:0]              wr_idx,
    input  logic [1:0]                    wr_kind,
    input  logic [LVL_W-1:0]              wr_data,
    output logic [NUM_SRC-1:0]            src_req,
    output logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl
);

    wr_kind_e kind;
    assign kind = wr_kind_e'(wr_kind);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic             sel;
        logic             cause_q;
        logic             en_q;
        logic [LVL_W-1:0] lvl_q;

        assign sel = wr_en && (wr_idx == SRC_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cause_q <= 1'b0;
                en_q    <= 1'b0;
                lvl_q   <= LVL_OFF;
            end else begin
                // a fresh event is never lost to a simultaneous clear
                if (cause_set[g]) begin
                    cause_q <= 1'b1;
                end else if (sel && kind == WK_CLEAR) begin
                    cause_q <= 1'b0;
                end
                if (sel && kind == WK_ENABLE) begin
                    en_q <= wr_data[0];
                end
                if (sel && kind == WK_LEVEL) begin
                    lvl_q <= wr_data;
                end
            end
        end

        assign src_req[g] = cause_q && en_q && (lvl_q != LVL_OFF);
        assign src_lvl[g] = lvl_q;

        // R1: a requesting source never carries the disabled level
        p_no_off_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[g] |-> (src_lvl[g] != LVL_OFF));
    end

endmodule

// File: rtl/lic_arbiter.sv
module lic_arbiter
    import lic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input  logic [NUM_SRC-1:0]            src_req,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
    output logic                          win_vld,
    output logic [SRC_W-1:0]              win_idx,
    output logic [LVL_W-1:0]              win_lvl
);

    // strict compare while scanning upward keeps the lowest index on ties
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        win_lvl = LVL_OFF;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_req[i] && (src_lvl[i] < win_lvl)) begin
                win_vld = 1'b1;
                win_idx = SRC_W'(i);
                win_lvl = src_lvl[i];
            end
        end
    end

endmodule

// File: rtl/lic_ctx_stack.sv
module lic_ctx_stack
    import lic_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  ctx_t push_ctx,
    output ctx_t top_ctx,
    output logic empty,
    output logic full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    ctx_t             mem [DEPTH];
    logic [CNT_W-1:0] fill;
    logic [CNT_W-1:0] top_pos;

    assign top_pos = fill - CNT_W'(1);
    assign empty   = (fill == '0);
    assign full    = (fill == CNT_W'(DEPTH));
    assign top_ctx = mem[top_pos[PTR_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push) begin
            mem[fill[PTR_W-1:0]] <= push_ctx;
            fill <= fill + CNT_W'(1);
        end else if (pop) begin
            fill <= top_pos;
        end
    end

    // R12: acceptance logic must never push into a full stack
    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9: a return never pops an empty stack
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R9: push and pop are mutually exclusive
    p_push_pop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int WAIT_N    = 1,
    parameter int STK_DEPTH = 4,
    localparam int SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cause_set,
    input  logic               wr_en,
    input  logic [SRC_W-1:0]   wr_idx,
    input  logic [1:0]         wr_kind,
    input  logic [2:0]         wr_data,
    input  logic               ie_wr,
    input  logic               ie_val,
    input  logic               insn_end,
    input  logic               ret_req,
    output logic [2:0]         req_lvl,
    output logic [2:0]         cur_mask,
    output logic               ie_flag,
    output logic               busy,
    output logic               take_pulse,
    output logic [SRC_W-1:0]   take_idx
);

    localparam int ENTRY_CYC = 24 + 6 * WAIT_N;
    localparam int LEAVE_CYC = 15 + 6 * WAIT_N;
    localparam int CNT_W     = $clog2(ENTRY_CYC + 1);

    logic [NUM_SRC-1:0]            src_req;
    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
    logic                          win_vld;
    logic [SRC_W-1:0]              win_idx;
    logic [LVL_W-1:0]              win_lvl;

    lic_state_e       state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic             idle;
    logic             do_take;
    logic             do_ret;
    ctx_t             push_ctx;
    ctx_t             top_ctx;
    logic             stk_empty;
    logic             stk_full;

    lic_src_bank #(
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_set (cause_set),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_kind   (wr_kind),
        .wr_data   (wr_data),
        .src_req   (src_req),
        .src_lvl   (src_lvl)
    );

    lic_arbiter #(
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) i_arb (
        .src_req (src_req),
        .src_lvl (src_lvl),
        .win_vld (win_vld),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    assign push_ctx = '{mask: cur_mask, ie: ie_flag};

    lic_ctx_stack #(
        .DEPTH (STK_DEPTH)
    ) i_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_take),
        .pop      (do_ret),
        .push_ctx (push_ctx),
        .top_ctx  (top_ctx),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    // decision terms: a return takes precedence over an acceptance
    assign idle    = (state == ST_IDLE);
    assign do_ret  = idle && ret_req && !stk_empty;
    assign do_take = idle && !do_ret && insn_end && win_vld
                     && (win_lvl < cur_mask) && ie_flag && !stk_full;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (do_ret) begin
                    nxt_state = ST_LEAVE;
                    nxt_cnt   = CNT_W'(LEAVE_CYC - 1);
                end else if (do_take) begin
                    nxt_state = ST_ENTER;
                    nxt_cnt   = CNT_W'(ENTRY_CYC - 1);
                end
            end
            ST_ENTER, ST_LEAVE: begin
                if (cnt == '0) begin
                    nxt_state = ST_IDLE;
                end else begin
                    nxt_cnt = cnt - CNT_W'(1);
                end
            end
            default: begin
                nxt_state = ST_IDLE;
                nxt_cnt   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // outputs and processor-side context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_pulse <= 1'b0;
            take_idx   <= '0;
            cur_mask   <= LVL_OFF;
            ie_flag    <= 1'b0;
        end else begin
            take_pulse <= do_take;
            if (do_take) begin
                take_idx <= win_idx;
                cur_mask <= win_lvl;
            end else if (do_ret) begin
                cur_mask <= top_ctx.mask;
            end
            if (do_ret) begin
                ie_flag <= top_ctx.ie;
            end else if (ie_wr) begin
                ie_flag <= ie_val;
            end
        end
    end

    assign busy    = !idle;
    assign req_lvl = win_lvl;

    // R3: no requesting source is more urgent than the forwarded level
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        p_req_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[g] |-> (win_vld && (req_lvl <= src_lvl[g])));
    end

    // R4: an entry follows only a more urgent level with the flag set
    p_take_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> ($past(ie_flag) && ($past(req_lvl) < $past(cur_mask))));
    // R5: the mask carries the accepted level
    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> (cur_mask == $past(req_lvl)));
    // R6: entry only at an instruction boundary
    p_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> $past(insn_end));
    // R7: the entry pulse lasts one cycle
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |=> !take_pulse);
    // R8: no entry while a sequence is running
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !take_pulse);
    // R8: every entry starts a busy period
    p_take_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> busy);

endmodule

// File: tb/test_lvl_irq_ctrl.sv
module test_lvl_irq_ctrl;

    localparam int NSRC  = 8;
    localparam int WN    = 1;
    localparam int STK   = 4;
    localparam int SW    = 3;
    localparam int T_ENT = 24 + 6 * WN;
    localparam int T_RET = 15 + 6 * WN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] cause_set = '0;
    logic            wr_en = 1'b0;
    logic [SW-1:0]   wr_idx = '0;
    logic [1:0]      wr_kind = 2'd0;
    logic [2:0]      wr_data = 3'd0;
    logic            ie_wr = 1'b0;
    logic            ie_val = 1'b0;
    logic            insn_end = 1'b0;
    logic            ret_req = 1'b0;
    logic [2:0]      req_lvl;
    logic [2:0]      cur_mask;
    logic            ie_flag;
    logic            busy;
    logic            take_pulse;
    logic [SW-1:0]   take_idx;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    lvl_irq_ctrl #(
        .NUM_SRC   (NSRC),
        .WAIT_N    (WN),
        .STK_DEPTH (STK)
    ) i_lvl_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause_set  (cause_set),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_kind    (wr_kind),
        .wr_data    (wr_data),
        .ie_wr      (ie_wr),
        .ie_val     (ie_val),
        .insn_end   (insn_end),
        .ret_req    (ret_req),
        .req_lvl    (req_lvl),
        .cur_mask   (cur_mask),
        .ie_flag    (ie_flag),
        .busy       (busy),
        .take_pulse (take_pulse),
        .take_idx   (take_idx)
    );

    // behavioural reference model
    int m_cause [NSRC];
    int m_en    [NSRC];
    int m_lvl   [NSRC];
    int m_mask, m_ie, m_busy, m_left, m_take, m_idx;
    int q_mask [$];
    int q_ie   [$];

    function automatic void m_pick(output int wi, output int wl);
        wl = 7;
        wi = 0;
        for (int i = 0; i < NSRC; i++) begin
            if (m_cause[i] != 0 && m_en[i] != 0 && m_lvl[i] != 7 && m_lvl[i] < wl) begin
                wl = m_lvl[i];
                wi = i;
            end
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                m_cause[i] = 0;
                m_en[i] = 0;
                m_lvl[i] = 7;
            end
            m_mask = 7; m_ie = 0; m_busy = 0; m_left = 0; m_take = 0; m_idx = 0;
            q_mask.delete();
            q_ie.delete();
        end else begin
            int wi, wl;
            bit ret_now, take_now;
            m_pick(wi, wl);
            ret_now  = (m_busy == 0) && ret_req && (q_mask.size() > 0);
            take_now = (m_busy == 0) && !ret_now && insn_end && (wl < m_mask)
                       && (m_ie != 0) && (q_mask.size() < STK);
            m_take = take_now ? 1 : 0;
            if (take_now) begin
                q_mask.push_back(m_mask);
                q_ie.push_back(m_ie);
                m_mask = wl;
                m_idx = wi;
                m_busy = 1;
                m_left = T_ENT - 1;
            end else if (ret_now) begin
                m_mask = q_mask.pop_back();
                m_ie = q_ie.pop_back();
                m_busy = 1;
                m_left = T_RET - 1;
            end else if (m_busy != 0) begin
                if (m_left == 0) m_busy = 0;
                else m_left--;
            end
            if (!ret_now && ie_wr) m_ie = ie_val;
            for (int i = 0; i < NSRC; i++) begin
                bit hit;
                hit = wr_en && (int'(wr_idx) == i);
                if (cause_set[i]) m_cause[i] = 1;
                else if (hit && wr_kind == 2'd2) m_cause[i] = 0;
                if (hit && wr_kind == 2'd0) m_en[i] = wr_data[0];
                if (hit && wr_kind == 2'd1) m_lvl[i] = wr_data;
            end
        end
    end

    task automatic cmp(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int wi, wl;
            m_pick(wi, wl);
            cmp("R3", "req_lvl", int'(req_lvl), wl);
            cmp("R5", "cur_mask", int'(cur_mask), m_mask);
            cmp("R10", "ie_flag", int'(ie_flag), m_ie);
            cmp("R8", "busy", int'(busy), m_busy);
            cmp("R7", "take_pulse", int'(take_pulse), m_take);
            cmp("R7", "take_idx", int'(take_idx), m_idx);
        end
    end

    // stimulus helpers, each entered and left at a falling edge
    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int idx, int kind, int data);
        wr_en = 1'b1; wr_idx = SW'(idx); wr_kind = 2'(kind); wr_data = 3'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic raise(int idx);
        cause_set[idx] = 1'b1;
        @(negedge clk);
        cause_set = '0;
    endtask

    task automatic boundary();
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
    endtask

    task automatic do_return();
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
    endtask

    task automatic set_ie(int v);
        ie_wr = 1'b1; ie_val = v[0];
        @(negedge clk);
        ie_wr = 1'b0;
    endtask

    task automatic busy_len(string tag, int exp);
        int n = 0;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
        end
        cmp(tag, "busy length", n, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R11: reset state
        cmp("R11", "cur_mask", int'(cur_mask), 7);
        cmp("R11", "ie_flag", int'(ie_flag), 0);
        cmp("R11", "busy", int'(busy), 0);
        cmp("R11", "take_pulse", int'(take_pulse), 0);
        cmp("R11", "req_lvl", int'(req_lvl), 7);

        // R1 R2 R3: a disabled source is ignored, ties go to the lower index
        wr(3, 1, 4); wr(3, 0, 1);
        wr(5, 1, 4); wr(5, 0, 1);
        wr(1, 1, 2);
        raise(1); raise(3); raise(5);
        cmp("R1", "req_lvl", int'(req_lvl), 4);

        // R4: global flag clear blocks acceptance
        boundary();
        cmp("R4", "take_pulse", int'(take_pulse), 0);
        set_ie(1);
        // R6: no boundary strobe, no acceptance
        step(3);
        cmp("R6", "cur_mask", int'(cur_mask), 7);
        boundary();
        cmp("R7", "take_pulse", int'(take_pulse), 1);
        cmp("R3", "take_idx", int'(take_idx), 3);
        cmp("R5", "cur_mask", int'(cur_mask), 4);
        busy_len("R8", T_ENT);
        cmp("R7", "take_pulse after", int'(take_pulse), 0);

        // nested entry at a more urgent level
        wr(1, 0, 1);
        cmp("R3", "req_lvl", int'(req_lvl), 2);
        boundary();
        cmp("R5", "take_idx", int'(take_idx), 1);
        cmp("R5", "cur_mask", int'(cur_mask), 2);
        step(T_ENT + 2);

        // R4: a level equal to the mask is not taken
        wr(0, 1, 2); wr(0, 0, 1); raise(0);
        boundary();
        cmp("R4", "take_pulse", int'(take_pulse), 0);
        cmp("R4", "cur_mask", int'(cur_mask), 2);
        wr(0, 2, 0); wr(1, 2, 0);

        // R9: returns restore the saved context
        do_return();
        cmp("R9", "cur_mask", int'(cur_mask), 4);
        busy_len("R9", T_RET);
        do_return();
        cmp("R9", "cur_mask", int'(cur_mask), 7);
        step(T_RET + 2);
        do_return();
        cmp("R9", "busy on empty return", int'(busy), 0);
        cmp("R9", "cur_mask", int'(cur_mask), 7);

        // R2: kind 3 writes change nothing
        wr(3, 3, 0); wr(5, 3, 0);
        cmp("R2", "req_lvl", int'(req_lvl), 4);
        wr(3, 2, 0); wr(5, 2, 0);
        cmp("R2", "req_lvl after clears", int'(req_lvl), 7);

        // R1: level 7 never requests
        wr(6, 0, 1); raise(6);
        cmp("R1", "req_lvl", int'(req_lvl), 7);
        boundary();
        cmp("R1", "take_pulse", int'(take_pulse), 0);

        // R1: set beats clear in the same cycle
        wr(2, 1, 5); wr(2, 0, 1);
        cause_set[2] = 1'b1;
        wr(2, 2, 0);
        cause_set = '0;
        cmp("R1", "req_lvl", int'(req_lvl), 5);

        // R10: a popping return wins over an enable write
        boundary();
        cmp("R5", "cur_mask", int'(cur_mask), 5);
        step(T_ENT + 2);
        ie_wr = 1'b1; ie_val = 1'b0; ret_req = 1'b1;
        @(negedge clk);
        ie_wr = 1'b0; ret_req = 1'b0;
        cmp("R10", "ie_flag", int'(ie_flag), 1);
        cmp("R10", "cur_mask", int'(cur_mask), 7);
        step(T_RET + 2);
        set_ie(0);
        cmp("R10", "ie_flag", int'(ie_flag), 0);
        set_ie(1);

        // R12: fill the stack, then a more urgent request must wait
        wr(2, 2, 0);
        wr(0, 1, 6);
        wr(4, 1, 4); wr(4, 0, 1);
        wr(5, 1, 1);
        wr(7, 1, 0); wr(7, 0, 1);
        raise(0); boundary(); step(T_ENT + 2);
        raise(4); boundary(); step(T_ENT + 2);
        wr(6, 1, 3); boundary(); step(T_ENT + 2);
        raise(5); boundary(); step(T_ENT + 2);
        cmp("R12", "cur_mask full", int'(cur_mask), 1);
        raise(7);
        cmp("R12", "req_lvl", int'(req_lvl), 0);
        boundary();
        cmp("R12", "take_pulse full", int'(take_pulse), 0);
        cmp("R12", "cur_mask", int'(cur_mask), 1);
        do_return();
        cmp("R12", "cur_mask after pop", int'(cur_mask), 3);
        step(T_RET + 2);
        boundary();
        cmp("R12", "take_idx", int'(take_idx), 7);
        cmp("R12", "cur_mask", int'(cur_mask), 0);
        step(T_ENT + 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule